// File: doc/BRIEF.md
# HyperBus DDR Transaction Sequencer

This block is the master side of a HyperBus memory link. It takes one read or write request (space, word address, length in 16-bit words) and plays it out on the bus pins: chip select low, three clock cycles of command-address, an initial latency, then one 16-bit word per clock until the burst ends. The pins are modelled in a single clock domain. Each clock carries the two bytes that the real bus moves on its rising and falling edges, so `hb_dq_out`/`hb_dq_in` are 16 bits wide and the clock-enable output gates the bus clock.

A memory device that is about to run an internal refresh raises RWDS while it receives the command-address. When it does, the sequencer waits twice the programmed latency before data. The device's refresh scheme caps how long chip select may stay low. That cap is the array refresh period divided by the row count, then halved, and it is supplied as a cycle count. When a burst would run past the cap, the sequencer checks the elapsed low time at each word boundary. It raises chip select for one cycle and reopens a fresh transaction at the following address. The requester sees one continuous burst. `busy` covers the whole request.

Top module: `hbus_seq`

## Requirements
- R1: The three cycles after chip select falls carry the 48-bit command-address, most significant word first. Bit 47 is 1 for read and 0 for write. Bit 46 is 1 for register space. Bit 45 is 1 (linear burst). Bits 44:16 hold the word address shifted right by three. Bits 2:0 hold the low three address bits. All other bits are 0.
- R2: `hb_cs_n` is low and `hb_ck_en` is high exactly during command-address, latency and data cycles. Otherwise `hb_cs_n` is high and `hb_ck_en` is low.
- R3: After command-address, the sequencer holds chip select low with no data for `cfg_latency` cycles before the first data word.
- R4: If `hb_rwds_in` is high in any of the three command-address cycles, the latency for that transaction becomes twice `cfg_latency`.
- R5: Chip select may not stay low longer than `cfg_max_cs` cycles. After a data word, if words remain and the cycles spent low so far have reached `cfg_max_cs`, chip select goes high for one cycle. A new transaction then starts at the next word address.
- R6: During write data cycles, `wr_ready` is high, `hb_dq_oe` is high and `hb_dq_out` equals `wr_data`. `hb_dq_oe` is also high during command-address and low elsewhere.
- R7: During read data cycles, `rd_valid` is high and `rd_data` equals `hb_dq_in`. The bus is not driven in these cycles.
- R8: `busy` rises in the cycle after a request is accepted. It stays high through every split transaction and gap, and it falls after the last data word. `req_ready` is always the inverse of `busy`.
- R9: A request presented while `busy` is high is ignored. The running transfer keeps its own address, length and direction.
- R10: After reset, chip select is high, the clock is gated, the bus is not driven and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one bus clock per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released |
| cfg_latency | input | LATW | Initial latency in clock cycles |
| cfg_max_cs | input | CSW | Maximum chip-select low time in cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_reg | input | 1 | 1 = register space |
| req_addr | input | AW | Start word address |
| req_len | input | LENW | Burst length in 16-bit words (at least 1) |
| wr_data | input | 16 | Write word, taken when wr_ready is high |
| wr_ready | output | 1 | Write word consumed this cycle |
| rd_data | output | 16 | Read word |
| rd_valid | output | 1 | rd_data valid this cycle |
| hb_cs_n | output | 1 | Chip select, active low |
| hb_ck_en | output | 1 | Bus clock enable |
| hb_dq_out | output | 16 | Two DQ bytes driven this clock |
| hb_dq_oe | output | 1 | DQ output enable |
| hb_dq_in | input | 16 | Two DQ bytes sampled this clock |
| hb_rwds_in | input | 1 | RWDS as sampled from the device |
| busy | output | 1 | Request in progress |

## Verification
A wrong phase counter shows up within one cycle as a command-address word on `hb_dq_out` that differs from the expected word, or as a data strobe that comes one cycle early or late. A lost RWDS flag or a stale address shows up at the first data word after a gap, because the restarted command-address carries the next address. A faulty chip-select counter appears as a gap in the wrong cycle. The bench compares every port against a behavioural cycle trace on each clock, so every fault surfaces in the cycle it occurs.

// File: rtl/hbus_seq_pkg.sv
package hbus_seq_pkg;
  localparam int WORD_W = 16;
  localparam int CA_W   = 48;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CA,
    ST_LAT,
    ST_DATA,
    ST_GAP
  } seq_state_t;
endpackage

// File: rtl/hbus_ca_word.sv
module hbus_ca_word #(
  parameter int AW = 24
) (
  input  logic                              is_write,
  input  logic                              is_reg,
  input  logic [AW-1:0]                     addr,
  input  logic [1:0]                        slot,
  output logic [hbus_seq_pkg::WORD_W-1:0]   word
);
  import hbus_seq_pkg::*;

  localparam int UPPER_W = 29;

  logic [CA_W-1:0]    ca;
  logic [UPPER_W-1:0] upper;

  always_comb begin
    upper          = UPPER_W'(addr >> 3);
    ca             = '0;
    ca[47]         = ~is_write;
    ca[46]         = is_reg;
    ca[45]         = 1'b1;
    ca[44:16]      = upper;
    ca[2:0]        = addr[2:0];
    case (slot)
      2'd0:    word = ca[47:32];
      2'd1:    word = ca[31:16];
      default: word = ca[15:0];
    endcase
  end
endmodule

// File: rtl/hbus_cs_guard.sv
module hbus_cs_guard #(
  parameter int CSW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_low,
  input  logic [CSW-1:0] max_low,
  output logic           limit_hit
);
  logic [CSW-1:0] cnt_q, cnt_d;
  logic           cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!cs_low) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != '1) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // cycles low including the current one have reached the cap
  assign limit_hit = ({1'b0, cnt_q} + 1'b1) >= {1'b0, max_low};
endmodule

// File: rtl/hbus_seq.sv
module hbus_seq #(
  parameter int AW   = 24,
  parameter int LENW = 10,
  parameter int LATW = 4,
  parameter int CSW  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LATW-1:0]  cfg_latency,
  input  logic [CSW-1:0]   cfg_max_cs,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_reg,
  input  logic [AW-1:0]    req_addr,
  input  logic [LENW-1:0]  req_len,
  input  logic [15:0]      wr_data,
  output logic             wr_ready,
  output logic [15:0]      rd_data,
  output logic             rd_valid,
  output logic             hb_cs_n,
  output logic             hb_ck_en,
  output logic [15:0]      hb_dq_out,
  output logic             hb_dq_oe,
  input  logic [15:0]      hb_dq_in,
  input  logic             hb_rwds_in,
  output logic             busy
);
  import hbus_seq_pkg::*;

  localparam int LCW = LATW + 1;

  seq_state_t       st_q, st_d;
  logic [1:0]       slot_q, slot_d;
  logic [LCW-1:0]   lat_q, lat_d, lat_total;
  logic             dbl_q, dbl_d, dbl_now;
  logic [AW-1:0]    addr_q, addr_d;
  logic [LENW-1:0]  left_q, left_d;
  logic             wr_q, wr_d, reg_q, reg_d;
  logic             load_en;
  logic             cs_low, limit_hit;
  logic [15:0]      ca_word;

  hbus_ca_word #(.AW(AW)) u_ca (
    .is_write (wr_q),
    .is_reg   (reg_q),
    .addr     (addr_q),
    .slot     (slot_q),
    .word     (ca_word)
  );

  hbus_cs_guard #(.CSW(CSW)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_low    (cs_low),
    .max_low   (cfg_max_cs),
    .limit_hit (limit_hit)
  );

  assign dbl_now   = dbl_q | hb_rwds_in;
  assign lat_total = dbl_now ? {cfg_latency, 1'b0} : {1'b0, cfg_latency};

  always_comb begin
    st_d    = st_q;
    slot_d  = slot_q;
    lat_d   = lat_q;
    dbl_d   = dbl_q;
    addr_d  = addr_q;
    left_d  = left_q;
    wr_d    = wr_q;
    reg_d   = reg_q;
    load_en = 1'b1;
    case (st_q)
      ST_IDLE: begin
        load_en = req_valid;
        if (req_valid) begin
          st_d   = ST_CA;
          slot_d = 2'd0;
          dbl_d  = 1'b0;
          addr_d = req_addr;
          left_d = req_len;
          wr_d   = req_write;
          reg_d  = req_reg;
        end
      end
      ST_CA: begin
        dbl_d = dbl_now;
        if (slot_q == 2'd2) begin
          lat_d = lat_total;
          st_d  = (lat_total == '0) ? ST_DATA : ST_LAT;
        end else begin
          slot_d = slot_q + 2'd1;
        end
      end
      ST_LAT: begin
        if (lat_q <= LCW'(1)) st_d  = ST_DATA;
        else                  lat_d = lat_q - 1'b1;
      end
      ST_DATA: begin
        addr_d = addr_q + 1'b1;
        left_d = left_q - 1'b1;
        if (left_q <= LENW'(1)) st_d = ST_IDLE;
        else if (limit_hit)     st_d = ST_GAP;
      end
      ST_GAP: begin
        st_d   = ST_CA;
        slot_d = 2'd0;
        dbl_d  = 1'b0;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // rst_n is expected to arrive already synchronised on its release edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      slot_q <= '0;
      lat_q  <= '0;
      dbl_q  <= 1'b0;
      addr_q <= '0;
      left_q <= '0;
      wr_q   <= 1'b0;
      reg_q  <= 1'b0;
    end else if (load_en) begin
      st_q   <= st_d;
      slot_q <= slot_d;
      lat_q  <= lat_d;
      dbl_q  <= dbl_d;
      addr_q <= addr_d;
      left_q <= left_d;
      wr_q   <= wr_d;
      reg_q  <= reg_d;
    end
  end

  assign cs_low    = (st_q == ST_CA) || (st_q == ST_LAT) || (st_q == ST_DATA);
  assign hb_cs_n   = ~cs_low;
  assign hb_ck_en  = cs_low;
  assign wr_ready  = (st_q == ST_DATA) && wr_q;
  assign rd_valid  = (st_q == ST_DATA) && !wr_q;
  assign rd_data   = hb_dq_in;
  assign hb_dq_oe  = (st_q == ST_CA) || wr_ready;
  assign hb_dq_out = (st_q == ST_CA) ? ca_word : (wr_ready ? wr_data : '0);
  assign busy      = (st_q != ST_IDLE);
  assign req_ready = (st_q == ST_IDLE);
endmodule

// File: rtl/hbus_seq_chk.sv
module hbus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic busy,
  input logic hb_cs_n,
  input logic hb_ck_en,
  input logic hb_dq_oe,
  input logic wr_ready,
  input logic rd_valid
);
  a_r2_clock_gated: assert property (@(posedge clk) disable iff (!rst_n)
    hb_ck_en != hb_cs_n);

  a_r2_cs_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !hb_cs_n |-> busy);

  a_r8_ready_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready != busy);

  a_r6_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (hb_dq_oe && !hb_cs_n));

  a_r7_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!hb_dq_oe && !hb_cs_n && !wr_ready));

  a_r5_gap_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hb_cs_n) && busy) |=> !hb_cs_n);

  a_r1_ca_follows_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hb_cs_n) |-> hb_dq_oe);
endmodule

bind hbus_seq hbus_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .busy      (busy),
  .hb_cs_n   (hb_cs_n),
  .hb_ck_en  (hb_ck_en),
  .hb_dq_oe  (hb_dq_oe),
  .wr_ready  (wr_ready),
  .rd_valid  (rd_valid)
);

// File: tb/hbus_seq_test.sv
module hbus_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic [3:0]  cfg_latency;
  logic [9:0]  cfg_max_cs;
  logic        req_valid, req_ready, req_write, req_reg;
  logic [23:0] req_addr;
  logic [9:0]  req_len;
  logic [15:0] wr_data, rd_data, hb_dq_out, hb_dq_in;
  logic        wr_ready, rd_valid, hb_cs_n, hb_ck_en, hb_dq_oe, hb_rwds_in, busy;

  int nchk = 0;
  int nfail = 0;

  typedef struct packed {
    logic        req;
    logic        rwds;
    logic [15:0] din;
    logic [15:0] wdat;
    logic        cs_n;
    logic        oe;
    logic [15:0] dq;
    logic        rdv;
    logic        wrr;
    logic        bsy;
  } ent_t;

  ent_t plan_q[$];

  hbus_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_latency(cfg_latency), .cfg_max_cs(cfg_max_cs),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_reg(req_reg), .req_addr(req_addr), .req_len(req_len),
    .wr_data(wr_data), .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .hb_cs_n(hb_cs_n), .hb_ck_en(hb_ck_en), .hb_dq_out(hb_dq_out),
    .hb_dq_oe(hb_dq_oe), .hb_dq_in(hb_dq_in), .hb_rwds_in(hb_rwds_in), .busy(busy)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic chk(input bit ok, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [15:0] wval(int a);
    return 16'hA000 ^ 16'(a * 3);
  endfunction

  function automatic logic [15:0] rval(int a);
    return 16'h5A5A ^ 16'(a);
  endfunction

  function automatic ent_t filler(bit b, bit r);
    ent_t e;
    e.req  = r;   e.rwds = 1'b0; e.din = 16'hDEAD; e.wdat = 16'hBEEF;
    e.cs_n = 1'b1; e.oe = 1'b0;  e.dq = 16'h0;     e.rdv = 1'b0;
    e.wrr  = 1'b0; e.bsy = b;
    return e;
  endfunction

  // Behavioural trace of one request: list of per-cycle stimulus and expectation
  task automatic plan(input bit w, input bit r, input int addr, input int len,
                      input int lat, input int mx, input int rmask, input int rpos,
                      input bit hold);
    ent_t e;
    int a = addr;
    int left = len;
    int t = 0;
    int cs;
    int lt;
    logic [47:0] ca;
    plan_q.push_back(filler(1'b0, 1'b1));
    forever begin
      ca = '0;
      ca[47] = !w; ca[46] = r; ca[45] = 1'b1;
      ca[44:16] = 29'(a >> 3);
      ca[2:0] = 3'(a);
      for (int i = 0; i < 3; i++) begin
        e = filler(1'b1, hold);
        e.cs_n = 1'b0; e.oe = 1'b1; e.dq = ca[47 - 16*i -: 16];
        e.rwds = rmask[t] && (i == rpos);
        plan_q.push_back(e);
      end
      lt = rmask[t] ? 2 * lat : lat;
      for (int i = 0; i < lt; i++) begin
        e = filler(1'b1, hold);
        e.cs_n = 1'b0;
        plan_q.push_back(e);
      end
      cs = 3 + lt;
      forever begin
        e = filler(1'b1, hold);
        e.cs_n = 1'b0;
        if (w) begin
          e.oe = 1'b1; e.wrr = 1'b1; e.wdat = wval(a); e.dq = wval(a);
        end else begin
          e.rdv = 1'b1; e.din = rval(a);
        end
        plan_q.push_back(e);
        a++; left--; cs++;
        if (left == 0 || cs >= mx) break;
      end
      if (left == 0) break;
      plan_q.push_back(filler(1'b1, hold));
      t++;
    end
    plan_q.push_back(filler(1'b0, 1'b0));
  endtask

  task automatic run(input string tag, input bit w, input bit r, input int addr,
                     input int len, input int lat, input int mx, input int rmask,
                     input int rpos, input bit hold);
    ent_t e;
    plan(w, r, addr, len, lat, mx, rmask, rpos, hold);
    cfg_latency = 4'(lat);
    cfg_max_cs  = 10'(mx);
    for (int k = 0; k < plan_q.size(); k++) begin
      e = plan_q[k];
      @(negedge clk);
      req_valid  = e.req;
      hb_rwds_in = e.rwds;
      hb_dq_in   = e.din;
      wr_data    = e.wdat;
      if (k == 0) begin
        req_write = w; req_reg = r; req_addr = 24'(addr); req_len = 10'(len);
      end else begin
        req_write = !w; req_reg = !r; req_addr = 24'h0ABCDE; req_len = 10'd7;
      end
      #1;
      chk(hb_cs_n === e.cs_n, {tag, " R2 cs_n"}, 16'(hb_cs_n), 16'(e.cs_n));
      chk(hb_ck_en === !e.cs_n, {tag, " R2 ck_en"}, 16'(hb_ck_en), 16'(!e.cs_n));
      chk(hb_dq_oe === e.oe, {tag, " R6 dq_oe"}, 16'(hb_dq_oe), 16'(e.oe));
      if (e.oe)
        chk(hb_dq_out === e.dq, {tag, e.wrr ? " R6 write word" : " R1 ca word"},
            hb_dq_out, e.dq);
      chk(wr_ready === e.wrr, {tag, " R6 wr_ready"}, 16'(wr_ready), 16'(e.wrr));
      chk(rd_valid === e.rdv, {tag, " R7 rd_valid"}, 16'(rd_valid), 16'(e.rdv));
      if (e.rdv)
        chk(rd_data === e.din, {tag, " R7 rd_data"}, rd_data, e.din);
      chk(busy === e.bsy, {tag, " R8 busy"}, 16'(busy), 16'(e.bsy));
      chk(req_ready === !e.bsy, {tag, " R8 req_ready"}, 16'(req_ready), 16'(!e.bsy));
    end
    plan_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_reg = 1'b0; req_addr = '0; req_len = '0;
    wr_data = '0; hb_dq_in = '0; hb_rwds_in = 1'b0;
    cfg_latency = 4'd3; cfg_max_cs = 10'd12;
    repeat (3) @(negedge clk);
    // R10: idle state under reset
    chk(hb_cs_n === 1'b1, "R10 cs_n", 16'(hb_cs_n), 16'd1);
    chk(hb_ck_en === 1'b0, "R10 ck_en", 16'(hb_ck_en), 16'd0);
    chk(hb_dq_oe === 1'b0, "R10 dq_oe", 16'(hb_dq_oe), 16'd0);
    chk(busy === 1'b0, "R10 busy", 16'(busy), 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && hb_cs_n === 1'b1, "R10 after release", 16'(busy), 16'd0);

    // R1 R3 R6: plain memory write, no refresh flag
    run("R3", 1'b1, 1'b0, 'h12345, 4, 3, 12, 0, 0, 1'b0);
    // R4 R5 R7: read, RWDS on first transaction doubles latency, forces a split
    run("R4", 1'b0, 1'b0, 'h00FFF7, 5, 3, 12, 1, 1, 1'b0);
    // R9: register read with a competing request held high while busy
    run("R9", 1'b0, 1'b1, 5, 1, 3, 12, 0, 0, 1'b1);
    // R5: long write split repeatedly, RWDS on second transaction's last CA cycle
    run("R5", 1'b1, 1'b0, 'h2FFFFE, 20, 3, 12, 2, 2, 1'b0);
    // R5: tight cap, one word per transaction
    run("R5 tight", 1'b0, 1'b0, 'h40, 3, 1, 5, 0, 0, 1'b0);
    // R3: zero latency goes straight from command-address to data
    run("R3 zero", 1'b1, 1'b1, 'h7, 2, 0, 12, 1, 0, 1'b0);

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule